// File: doc/BRIEF.md
# Rotating-Priority Single-Grant Request Picker

This block takes a vector of request bits and returns a vector in which at most one bit is set, and that bit is always one of the set request bits. It has no clock and no reset: the grant follows the inputs within the same cycle. A two-bit mode input picks how the winner is chosen. One mode favours the bottom of the vector. One favours the top. The third is a rotating mode, where the search begins at the position marked by a one-hot priority vector and moves toward higher indices, wrapping from the top bit to bit 0.

The rotating mode is the building block of a fair arbiter. The surrounding logic holds the priority pointer and moves it after each grant, usually to the position just above the winner. This block only makes the combinational choice, so the user decides the fairness policy. The width is set by the parameter `N`.

Top module: `rr_onehot_masker`

## Requirements
- R1: `grant_o` never has more than one bit set.
- R2: Every set bit of `grant_o` is also set in `req_i`.
- R3: When `req_i` is all zeros, `grant_o` is all zeros in every mode.
- R4: With `mode_i` = 2'd0, `grant_o` holds only the lowest-index set bit of `req_i`.
- R5: With `mode_i` = 2'd1, `grant_o` holds only the highest-index set bit of `req_i`.
- R6: With `mode_i` = 2'd2, the search starts at the index of the set bit in `prio_i` and moves upward. That index is itself a candidate, so a request there wins.
- R7: In `mode_i` = 2'd2, if no request is set at or above the priority index, the search wraps to bit 0 and keeps moving upward.
- R8: With N = 4, `mode_i` = 2'd2, `req_i` = 4'b1001 and `prio_i` = 4'b0010, `grant_o` is 4'b1000.
- R9: `mode_i` = 2'd3 behaves exactly like `mode_i` = 2'd0.
- R10: If `req_i` has any bit set, `grant_o` has exactly one bit set.
- R11: In `mode_i` = 2'd2, `prio_i` must be one-hot. The result is undefined otherwise, and an assertion flags the violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| req_i | input | N | Request bits, one per requester |
| prio_i | input | N | One-hot start position for the rotating search |
| mode_i | input | 2 | 0 lowest, 1 highest, 2 rotating, 3 lowest |
| grant_o | output | N | Single-bit grant, or zero when no request is set |

## Verification
The checker assumes that, whenever the rotating mode is selected, `prio_i` carries exactly one set bit. It also assumes that all inputs change together in one step, so no mixed state is ever observed. The bench drives every input from a single task in one time step. In the rotating mode it draws `prio_i` only from the N legal one-hot values, both in the exhaustive sweep at N = 4 and in the random runs at N = 8. Non-one-hot priority values are used only in the modes that ignore the priority input.

// File: rtl/rr_mask_pkg.sv
package rr_mask_pkg;
  typedef enum logic [1:0] {
    PICK_LOW     = 2'd0,
    PICK_HIGH    = 2'd1,
    PICK_ROT     = 2'd2,
    PICK_LOW_ALT = 2'd3
  } pick_mode_e;
endpackage

// File: rtl/rr_isolate_lowest.sv
module rr_isolate_lowest #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] pick_o
);
  // keep only the lowest set bit: x & (-x)
  function automatic logic [W-1:0] lowest_of(input logic [W-1:0] x);
    return x & (~x + W'(1));
  endfunction

  assign pick_o = lowest_of(vec_i);
endmodule

// File: rtl/rr_isolate_highest.sv
module rr_isolate_highest #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec_i,
  output logic [W-1:0] pick_o
);
  logic [W-1:0] flipped;
  logic [W-1:0] flipped_pick;

  // mirror the vector, take the lowest bit, mirror back
  for (genvar g = 0; g < W; g++) begin : g_mirror
    assign flipped[g]       = vec_i[W-1-g];
    assign pick_o[W-1-g]    = flipped_pick[g];
  end

  rr_isolate_lowest #(.W(W)) u_low (
    .vec_i (flipped),
    .pick_o(flipped_pick)
  );
endmodule

// File: rtl/rr_rotate_pick.sv
module rr_rotate_pick #(
  parameter int W = 8
) (
  input  logic [W-1:0] vec_i,
  input  logic [W-1:0] start_i,
  output logic [W-1:0] pick_o
);
  localparam int W2 = 2 * W;

  logic [W2-1:0] doubled;
  logic [W2-1:0] below_start;
  logic [W2-1:0] eligible;
  logic [W2-1:0] first_hit;

  // two copies of the requests; the upper copy stands for the wrapped scan
  assign doubled     = {vec_i, vec_i};
  assign below_start = {{W{1'b0}}, start_i} - W2'(1);
  assign eligible    = doubled & ~below_start;

  rr_isolate_lowest #(.W(W2)) u_first (
    .vec_i (eligible),
    .pick_o(first_hit)
  );

  assign pick_o = first_hit[W-1:0] | first_hit[W2-1:W];
endmodule

// File: rtl/rr_onehot_masker.sv
module rr_onehot_masker
  import rr_mask_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] prio_i,
  input  logic [1:0]   mode_i,
  output logic [N-1:0] grant_o
);
  pick_mode_e   mode;
  logic [N-1:0] pick_low;
  logic [N-1:0] pick_high;
  logic [N-1:0] pick_rot;
  logic         any_req;

  assign mode    = pick_mode_e'(mode_i);
  assign any_req = |req_i;

  rr_isolate_lowest #(.W(N)) u_low (
    .vec_i (req_i),
    .pick_o(pick_low)
  );

  rr_isolate_highest #(.W(N)) u_high (
    .vec_i (req_i),
    .pick_o(pick_high)
  );

  rr_rotate_pick #(.W(N)) u_rot (
    .vec_i  (req_i),
    .start_i(prio_i),
    .pick_o (pick_rot)
  );

  always_comb begin
    unique case (mode)
      PICK_HIGH: grant_o = pick_high;
      PICK_ROT:  grant_o = pick_rot;
      default:   grant_o = pick_low;
    endcase
  end
endmodule

// File: rtl/rr_onehot_masker_chk.sv
module rr_onehot_masker_chk #(
  parameter int N = 8
) (
  input logic [N-1:0] req_i,
  input logic [N-1:0] prio_i,
  input logic [1:0]   mode_i,
  input logic [N-1:0] grant_o,
  input logic         any_req
);
  always_comb begin
    // R1
    grant_onehot_chk: assert ($onehot0(grant_o));
    // R2
    grant_subset_chk: assert ((grant_o & ~req_i) == '0);
    // R3
    if (!any_req) idle_zero_chk: assert (grant_o == '0);
    // R10
    if (any_req) busy_grant_chk: assert ($countones(grant_o) == 1);
    // R4 R9: no request below the winner
    if (mode_i != 2'd1 && mode_i != 2'd2 && grant_o != '0)
      low_first_chk: assert (((grant_o - N'(1)) & req_i) == '0);
    // R5: no request above the winner
    if (mode_i == 2'd1 && grant_o != '0)
      high_first_chk: assert ((req_i & ~(grant_o | (grant_o - N'(1)))) == '0);
    // R11
    if (mode_i == 2'd2) prio_onehot_chk: assert ($countones(prio_i) == 1);
  end
endmodule

bind rr_onehot_masker rr_onehot_masker_chk #(.N(N)) u_chk (
  .req_i  (req_i),
  .prio_i (prio_i),
  .mode_i (mode_i),
  .grant_o(grant_o),
  .any_req(any_req)
);

// File: tb/tb_rr_onehot_masker.sv
module tb_rr_onehot_masker;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;  // 200 MHz

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [3:0] req4, prio4, gnt4;
  logic [1:0] mode4;
  logic [7:0] req8, prio8, gnt8;
  logic [1:0] mode8;

  rr_onehot_masker #(.N(4)) dut (
    .req_i(req4), .prio_i(prio4), .mode_i(mode4), .grant_o(gnt4)
  );
  rr_onehot_masker #(.N(8)) dut_wide (
    .req_i(req8), .prio_i(prio8), .mode_i(mode8), .grant_o(gnt8)
  );

  // behavioural reference: walk the positions with integers
  function automatic int unsigned model(int n, int unsigned req,
                                        int unsigned prio, int mode);
    int start = 0;
    if (mode == 1) begin
      for (int i = n - 1; i >= 0; i--) if (req[i]) return 1 << i;
      return 0;
    end
    if (mode == 2) begin
      for (int i = 0; i < n; i++) if (prio[i]) start = i;
      for (int k = 0; k < n; k++) begin
        int idx = (start + k) % n;
        if (req[idx]) return 1 << idx;
      end
      return 0;
    end
    for (int i = 0; i < n; i++) if (req[i]) return 1 << i;
    return 0;
  endfunction

  function automatic string tag_of(int unsigned req, int unsigned prio, int mode, int n);
    if (req == 0) return "R3";
    if (mode == 1) return "R5";
    if (mode == 3) return "R9";
    if (mode == 0) return "R4";
    for (int i = 0; i < n; i++)
      if (prio[i]) begin
        if ((req >> i) == 0) return "R7";
        return "R6";
      end
    return "R6";
  endfunction

  task automatic apply4(input logic [3:0] r, input logic [3:0] p, input logic [1:0] m,
                        input string tag);
    int unsigned exp;
    @(posedge clk);
    req4 = r; prio4 = p; mode4 = m;
    @(negedge clk);
    exp = model(4, r, p, m);
    checks++;
    if (gnt4 !== exp[3:0]) begin
      fails++;
      $display("FAIL %s n=4 req=%b prio=%b mode=%0d got=%b exp=%b",
               tag, r, p, m, gnt4, exp[3:0]);
    end
  endtask

  task automatic apply8(input logic [7:0] r, input logic [7:0] p, input logic [1:0] m);
    int unsigned exp;
    @(posedge clk);
    req8 = r; prio8 = p; mode8 = m;
    @(negedge clk);
    exp = model(8, r, p, m);
    checks++;
    if (gnt8 !== exp[7:0]) begin
      fails++;
      $display("FAIL %s n=8 req=%b prio=%b mode=%0d got=%b exp=%b",
               tag_of(r, p, m, 8), r, p, m, gnt8, exp[7:0]);
    end
    // R1 R2 R10 shape check at the port
    checks++;
    if ($countones(gnt8) != (r != 0 ? 1 : 0) || (gnt8 & ~r) != 0) begin
      fails++;
      $display("FAIL R1/R2/R10 req=%b got=%b exp=one bit of req", r, gnt8);
    end
  endtask

  initial begin
    req4 = '0; prio4 = 4'b0001; mode4 = 2'd0;
    req8 = '0; prio8 = 8'h01;   mode8 = 2'd0;
    @(negedge clk);
    // R3 idle state
    checks++;
    if (gnt4 !== 4'b0 || gnt8 !== 8'b0) begin
      fails++;
      $display("FAIL R3 idle got=%b/%b exp=0", gnt4, gnt8);
    end
    // R8 stated example
    apply4(4'b1001, 4'b0010, 2'd2, "R8");
    // R6 priority slot itself wins
    apply4(4'b0110, 4'b0100, 2'd2, "R6");
    // R7 wrap past top
    apply4(4'b0011, 4'b1000, 2'd2, "R7");
    // exhaustive N=4: lowest, highest, alt-low with arbitrary prio
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 16; r++)
        if (m == 2) begin
          for (int p = 0; p < 4; p++)
            apply4(4'(r), 4'(1 << p), 2'(m), tag_of(r, 1 << p, m, 4));
        end else begin
          apply4(4'(r), 4'(r ^ 5), 2'(m), tag_of(r, 0, m, 4));
        end
    // random N=8
    for (int i = 0; i < 2000; i++) begin
      logic [1:0] m = 2'($urandom_range(0, 3));
      logic [7:0] r = 8'($urandom);
      logic [7:0] p = (m == 2'd2) ? 8'(1 << $urandom_range(0, 7)) : 8'($urandom);
      if (i % 7 == 0) r = '0;
      apply8(r, p, m);
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired got=hang exp=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule